// File: doc/BRIEF.md
# Smart Card Character Framer

This block builds and takes apart asynchronous smart card characters. Each character has a start bit, eight data bits and a parity bit. Three configuration inputs set the character convention. One picks the bit order, one inverts the data bits, and one picks odd or even parity. Driving all three low gives the direct convention. Driving all three high gives the inverse convention, where logical 1 is sent as the low line state A, logical 0 as the high state Z, and the most significant bit goes first.

The transmitter takes a byte through a ready/valid handshake. It then puts one bit on the line for each elementary time unit strobe that arrives from outside. The receiver samples its line only when its own strobe is high. It rebuilds the byte, checks the selected parity, and reports the result with a one-cycle valid pulse. Guard time, error signalling, baud generation and any software access sit outside this block.

Top module: `sc_char_framer`

## Requirements
- R1: After reset and whenever no character is being sent, `tx_line` is 1 (state Z), `tx_busy` is 0, `tx_ready` is 1 and `rx_valid` is 0.
- R2: The first bit of every transmitted character is 0 (state A), whatever the invert setting. Each bit holds the line until a `tx_tick` cycle ends it.
- R3: When `cfg_msb_first` is 0, data goes out bit 0 first. When it is 1, data goes out bit 7 first.
- R4: When `cfg_invert` is 1, each data bit is driven as its complement. Otherwise it is driven as-is. The setting never changes the parity bit.
- R5: The parity bit is computed over the logical, uninverted byte. It is driven as the XOR of the eight bits when `cfg_odd` is 0, and as the complement of that XOR when `cfg_odd` is 1.
- R6: With all controls 0, byte 0x3B gives the line sequence 0,1,1,0,1,1,1,0,0,1. With all controls 1, byte 0x3F gives 0,1,1,0,0,0,0,0,0,1. Both sequences cover the start bit, the data and the parity bit.
- R7: `tx_busy` rises in the cycle after a byte is accepted. It falls after the tenth `tx_tick`, which is the one that ends the parity bit. `tx_ready` is 0 while busy, and `tx_valid` has no effect while busy.
- R8: The receiver applies the inverse of the order and inversion mapping to the nine bits after a start bit. It pulses `rx_valid` for one cycle, the cycle after the strobe that samples the parity bit, and presents the rebuilt byte on `rx_data`.
- R9: `rx_perr` is 1 together with `rx_valid` exactly when the received parity bit differs from the value that R5 gives for the rebuilt byte.
- R10: A receive strobe while the receiver is idle and `rx_line` is 1 does not start a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_msb_first | input | 1 | 1: bit 7 first, 0: bit 0 first |
| cfg_invert | input | 1 | Invert the data bits on the line |
| cfg_odd | input | 1 | 1: odd parity, 0: even parity |
| tx_valid | input | 1 | Byte offered for transmit |
| tx_ready | output | 1 | Transmitter can accept a byte |
| tx_data | input | 8 | Byte to transmit |
| tx_tick | input | 1 | Elementary time unit strobe for transmit |
| tx_line | output | 1 | Transmit line level (1 = Z, 0 = A) |
| tx_busy | output | 1 | Character in progress |
| rx_tick | input | 1 | Sampling strobe for receive |
| rx_line | input | 1 | Receive line level |
| rx_valid | output | 1 | One-cycle pulse: character received |
| rx_data | output | 8 | Received byte |
| rx_perr | output | 1 | Parity error, valid with rx_valid |

## Verification
The hardest case to reach is a receive strobe landing on an idle, high line right next to real characters. Random strobe spacing alone seldom gives a clean check that such a strobe is ignored. The bench therefore sends idle strobes before each received frame, then checks that no valid pulse appears. On the transmit side it also raises `tx_valid` in the middle of a character, to show that a byte offered while busy changes nothing. Random bytes and configurations, with the parity bit sometimes corrupted, fill in the rest. The two start-character waveforms are checked as directed cases.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic LINE_A = 1'b0;
  localparam logic LINE_Z = 1'b1;

  typedef enum logic {RX_IDLE, RX_BITS} rx_phase_e;
endpackage

// File: rtl/sc_tx.sv
module sc_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         msb_first,
  input  logic         invert,
  input  logic         odd,
  input  logic         valid,
  output logic         ready,
  input  logic [W-1:0] data,
  input  logic         tick,
  output logic         line,
  output logic         busy
);
  import sc_pkg::*;

  localparam int FW    = W + 2;
  localparam int CNT_W = $clog2(FW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FW - 1);

  logic [W-1:0]     ordered;
  logic [W-1:0]     levels;
  logic             par_bit;
  logic [FW-1:0]    frame;
  logic [FW-1:0]    sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             accept;

  for (genvar i = 0; i < W; i++) begin : g_map
    assign ordered[i] = msb_first ? data[W-1-i] : data[i];
    assign levels[i]  = ordered[i] ^ invert;
  end

  assign par_bit = (^data) ^ odd;
  assign frame   = {par_bit, levels, LINE_A};
  assign accept  = valid && !busy_q;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (accept) begin
      sh_d   = frame;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q && tick) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
      end else begin
        sh_d  = {LINE_Z, sh_q[FW-1:1]};
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign line  = busy_q ? sh_q[0] : LINE_Z;
  assign busy  = busy_q;
  assign ready = !busy_q;
endmodule

// File: rtl/sc_rx.sv
module sc_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         msb_first,
  input  logic         invert,
  input  logic         odd,
  input  logic         tick,
  input  logic         line,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         perr
);
  import sc_pkg::*;

  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W);

  rx_phase_e        phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W:0]       sh_q, sh_d;
  logic             fire;
  logic [W-1:0]     ordered;
  logic [W-1:0]     rebuilt;
  logic             valid_q;
  logic [W-1:0]     data_q;
  logic             perr_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    fire    = 1'b0;
    if (tick) begin
      if (phase_q == RX_IDLE) begin
        if (line == LINE_A) begin
          phase_d = RX_BITS;
          cnt_d   = '0;
        end
      end else begin
        sh_d = {line, sh_q[W:1]};
        if (cnt_q == LAST) begin
          phase_d = RX_IDLE;
          fire    = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_unmap
    assign ordered[i] = sh_d[i] ^ invert;
    assign rebuilt[i] = msb_first ? ordered[W-1-i] : ordered[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= RX_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      perr_q  <= 1'b0;
    end else begin
      valid_q <= fire;
      perr_q  <= fire && (sh_d[W] != ((^rebuilt) ^ odd));
      if (fire) begin
        data_q <= rebuilt;
      end
    end
  end

  assign valid = valid_q;
  assign data  = data_q;
  assign perr  = perr_q;
endmodule

// File: rtl/sc_char_framer.sv
module sc_char_framer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_msb_first,
  input  logic         cfg_invert,
  input  logic         cfg_odd,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic [W-1:0] tx_data,
  input  logic         tx_tick,
  output logic         tx_line,
  output logic         tx_busy,
  input  logic         rx_tick,
  input  logic         rx_line,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  output logic         rx_perr
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sc_tx #(.W(W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .msb_first (cfg_msb_first),
    .invert    (cfg_invert),
    .odd       (cfg_odd),
    .valid     (tx_valid),
    .ready     (tx_ready),
    .data      (tx_data),
    .tick      (tx_tick),
    .line      (tx_line),
    .busy      (tx_busy)
  );

  sc_rx #(.W(W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .msb_first (cfg_msb_first),
    .invert    (cfg_invert),
    .odd       (cfg_odd),
    .tick      (rx_tick),
    .line      (rx_line),
    .valid     (rx_valid),
    .data      (rx_data),
    .perr      (rx_perr)
  );
endmodule

// File: rtl/sc_char_framer_chk.sv
module sc_char_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_tick,
  input logic tx_line,
  input logic tx_busy,
  input logic rx_valid,
  input logic rx_perr
);
  // R1: the line rests at state Z outside a character
  p_idle_z_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);

  // R2: a new character opens with state A
  p_start_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !tx_line);

  // R2: the line changes only on a strobe
  p_hold_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy) && !$past(tx_tick)) |-> $stable(tx_line));

  // R7: no acceptance while a character is running
  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !tx_ready);

  // R7: busy only starts from an accepted byte
  p_busy_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_valid && tx_ready));

  // R8: the valid strobe lasts one cycle
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R9: a parity error is only reported with data
  p_perr_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_perr |-> rx_valid);
endmodule

bind sc_char_framer sc_char_framer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_tick  (tx_tick),
  .tx_line  (tx_line),
  .tx_busy  (tx_busy),
  .rx_valid (rx_valid),
  .rx_perr  (rx_perr)
);

// File: tb/tb_sc_char_framer.sv
module tb_sc_char_framer;
  logic       clk;
  logic       rst_n;
  logic       cfg_msb_first, cfg_invert, cfg_odd;
  logic       tx_valid, tx_ready, tx_tick, tx_line, tx_busy;
  logic [7:0] tx_data;
  logic       rx_tick, rx_line, rx_valid, rx_perr;
  logic [7:0] rx_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  sc_char_framer dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert), .cfg_odd(cfg_odd),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_tick(tx_tick), .tx_line(tx_line), .tx_busy(tx_busy),
    .rx_tick(rx_tick), .rx_line(rx_line), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_perr(rx_perr)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [9:0] exp_frame(logic [7:0] d, logic msb, logic inv, logic odd);
    logic [9:0] f;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = (msb ? d[7-i] : d[i]) ^ inv;
    f[9] = (^d) ^ odd;
    return f;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] d, logic msb, logic inv, logic odd, bit poke, string req);
    logic [9:0] f;
    f = exp_frame(d, msb, inv, odd);
    @(negedge clk);
    cfg_msb_first = msb; cfg_invert = inv; cfg_odd = odd;
    tx_data = d; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    tx_data = ~d;
    check("R7 busy after accept", tx_busy, 1);
    for (int k = 0; k < 10; k++) begin
      if (poke && k == 3) tx_valid = 1;
      if (poke && k == 5) tx_valid = 0;
      if (poke && k == 4) check("R7 ready low while busy", tx_ready, 0);
      for (int g = 0; g < int'($urandom_range(0, 2)); g++) @(negedge clk);
      check(req, tx_line, f[k]);
      tx_tick = 1;
      @(negedge clk);
      tx_tick = 0;
    end
    check("R7 busy drops after parity", tx_busy, 0);
    check("R1 idle line Z", tx_line, 1);
  endtask

  task automatic recv(logic [7:0] d, logic msb, logic inv, logic odd, bit corrupt);
    logic [9:0] f;
    f = exp_frame(d, msb, inv, odd);
    if (corrupt) f[9] = ~f[9];
    @(negedge clk);
    cfg_msb_first = msb; cfg_invert = inv; cfg_odd = odd;
    for (int k = 0; k < 2; k++) begin
      rx_line = 1; rx_tick = 1;
      @(negedge clk);
      rx_tick = 0;
      @(negedge clk);
    end
    check("R10 idle strobe ignored", rx_valid, 0);
    for (int k = 0; k < 10; k++) begin
      rx_line = f[k]; rx_tick = 1;
      @(negedge clk);
      rx_tick = 0;
      if (k < 9) begin
        check("R10 no early valid", rx_valid, 0);
        for (int g = 0; g < int'($urandom_range(0, 2)); g++) @(negedge clk);
      end
    end
    rx_line = 1;
    check("R8 rx_valid pulse", rx_valid, 1);
    check("R8 rx_data", rx_data, d);
    check("R9 rx_perr", rx_perr, corrupt);
    @(negedge clk);
    check("R8 valid one cycle", rx_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5C3F));
    rst_n = 0;
    cfg_msb_first = 0; cfg_invert = 0; cfg_odd = 0;
    tx_valid = 0; tx_data = 0; tx_tick = 0; rx_tick = 0; rx_line = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 reset tx_line", tx_line, 1);
    check("R1 reset tx_busy", tx_busy, 0);
    check("R1 reset tx_ready", tx_ready, 1);
    check("R1 reset rx_valid", rx_valid, 0);

    send(8'h3B, 0, 0, 0, 0, "R6 direct start char");
    send(8'h3F, 1, 1, 1, 0, "R6 inverse start char");
    send(8'hA5, 0, 1, 0, 1, "R4 invert data only");
    send(8'h01, 1, 0, 0, 0, "R3 msb first order");
    send(8'h01, 0, 0, 1, 0, "R5 odd parity");
    send(8'h00, 1, 1, 0, 0, "R2 start A under invert");
    recv(8'h3B, 0, 0, 0, 0);
    recv(8'h3F, 1, 1, 1, 0);
    recv(8'h3F, 1, 1, 1, 1);

    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      logic [2:0] c;
      d = 8'($urandom);
      c = 3'($urandom);
      send(d, c[0], c[1], c[2], n % 5 == 0, "R3 R4 R5 random frame");
      recv(d, c[0], c[1], c[2], ($urandom_range(0, 3) == 0));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule